// File: doc/BRIEF.md
# Clock Presence Watchdog

This block decides whether a valid Manchester bit clock is still arriving. It does not use analog carrier-detect or signal-strength indications. Instead it measures the spacing between recovered clock edges. A clock decoder upstream sends a one-cycle strobe each time it recovers a clock edge. The block tracks how many system cycles have passed since the last strobe.

A healthy clock produces an edge at least once per bit period. The watchdog allows a gap of up to 1.1 bit periods, which covers a 10% error in clock rate. Every strobe restarts the watchdog. If the allowance runs out with no strobe, the block does three things:
- drops its presence flag;
- emits one single-cycle loss event;
- parks its timer until the next edge.

The bit period is a parameter, given in system cycles.

Top module: `clkPresenceWatchdog`

## Requirements
- R1: While reset is held and after its release with no strobe, `clkPresent` and `lossPulse` are both 0.
- R2: A strobe sampled high on a rising edge of `clk` makes `clkPresent` 1 from that edge on, and `lossPulse` is 0 in the following cycle.
- R3: The timeout is TIMEOUT = floor(PERIOD_CYCLES * 11 / 10) system cycles (22 for the default of 20).
- R4: While consecutive strobes are at most TIMEOUT cycles apart, `clkPresent` stays 1 and no loss event occurs.
- R5: If TIMEOUT rising edges pass after a strobe with no further strobe, then on the TIMEOUT-th of them `clkPresent` falls to 0 and `lossPulse` rises for exactly one cycle. This is the only way `clkPresent` falls outside reset.
- R6: After a loss, no further loss event occurs and `clkPresent` stays 0 until the next strobe, however long the line stays quiet.
- R7: A strobe on the same edge on which the timeout would expire wins: the timer restarts, no loss event occurs and `clkPresent` stays 1.
- R8: A strobe after a loss re-acquires the clock (`clkPresent` 1) and restarts the full TIMEOUT window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| edgeStrobe | input | 1 | One-cycle pulse per recovered clock edge |
| clkPresent | output | 1 | 1 while a valid clock is judged present |
| lossPulse | output | 1 | One-cycle pulse when the clock is declared lost |

## Verification
The bench sweeps the gap between two strobes from one cycle to well past the timeout.

- The gap equal to TIMEOUT catches a design that lets expiry win over a coinciding strobe; such a design would emit a spurious loss and briefly drop presence.
- The gap of TIMEOUT+1 catches an off-by-one in the limit compare; such a design would either miss the loss or report it one cycle early or late.
- A long silence after a loss catches a timer that is not parked; such a design would repeat the loss pulse or let it last more than one cycle.
- A reacquisition afterwards shows that the window is counted fresh from the new strobe.

// File: rtl/clkWatchdogPkg.sv
package clkWatchdogPkg;

  // Strobes from the control FSM to the gap counter
  typedef struct packed {
    logic restart;  // clear the elapsed count
    logic advance;  // count one more quiet cycle
  } wdCtl_t;

  typedef enum logic {
    WD_IDLE  = 1'b0,
    WD_TRACK = 1'b1
  } wdState_t;

  function automatic int unsigned timeoutOf(input int unsigned periodCycles);
    return (periodCycles * 11) / 10;
  endfunction

endpackage

// File: rtl/clkWatchdogCounter.sv
module clkWatchdogCounter
  import clkWatchdogPkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 22,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic   clk,
  input  logic   rstN,
  input  wdCtl_t ctl,
  output logic   atLimit
);

  logic [CNT_W-1:0] elapsedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsedQ <= '0;
    end else if (ctl.restart) begin
      elapsedQ <= '0;
    end else if (ctl.advance) begin
      elapsedQ <= elapsedQ + 1'b1;
    end
  end

  // One more quiet cycle completes the allowed window
  assign atLimit = (elapsedQ == CNT_W'(TIMEOUT_CYCLES - 1));

endmodule

// File: rtl/clkWatchdogCtrl.sv
module clkWatchdogCtrl
  import clkWatchdogPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   edgeStrobe,
  input  logic   atLimit,
  output wdCtl_t ctl,
  output logic   clkPresent,
  output logic   lossPulse
);

  wdState_t stateQ, stateD;
  logic     lossD;

  always_comb begin
    stateD      = stateQ;
    lossD       = 1'b0;
    ctl.restart = 1'b0;
    ctl.advance = 1'b0;
    unique case (stateQ)
      WD_IDLE: begin
        if (edgeStrobe) begin
          ctl.restart = 1'b1;
          stateD      = WD_TRACK;
        end
      end
      WD_TRACK: begin
        if (edgeStrobe) begin
          ctl.restart = 1'b1;        // an edge always wins over expiry
        end else if (atLimit) begin
          stateD = WD_IDLE;
          lossD  = 1'b1;
        end else begin
          ctl.advance = 1'b1;
        end
      end
      default: stateD = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= WD_IDLE;
      lossPulse <= 1'b0;
    end else begin
      stateQ    <= stateD;
      lossPulse <= lossD;
    end
  end

  assign clkPresent = (stateQ == WD_TRACK);

endmodule

// File: rtl/clkPresenceWatchdog.sv
module clkPresenceWatchdog
  import clkWatchdogPkg::*;
#(
  parameter int unsigned PERIOD_CYCLES = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic edgeStrobe,
  output logic clkPresent,
  output logic lossPulse
);

  localparam int unsigned TIMEOUT_CYCLES = timeoutOf(PERIOD_CYCLES);

  wdCtl_t ctl;
  logic   atLimit;

  clkWatchdogCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .edgeStrobe (edgeStrobe),
    .atLimit    (atLimit),
    .ctl        (ctl),
    .clkPresent (clkPresent),
    .lossPulse  (lossPulse)
  );

  clkWatchdogCounter #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_counter (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .atLimit (atLimit)
  );

endmodule

// File: rtl/clkPresenceChecker.sv
module clkPresenceChecker #(
  parameter int unsigned TIMEOUT_CYCLES = 22,
  localparam int unsigned GAP_W = $clog2(TIMEOUT_CYCLES + 2)
) (
  input logic clk,
  input logic rstN,
  input logic edgeStrobe,
  input logic clkPresent,
  input logic lossPulse
);

  // Independent count of quiet edges since the last strobe, saturating
  logic [GAP_W-1:0] sinceEdge;
  logic             seenEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceEdge <= '0;
      seenEdge  <= 1'b0;
    end else if (edgeStrobe) begin
      sinceEdge <= '0;
      seenEdge  <= 1'b1;
    end else if (sinceEdge != GAP_W'(TIMEOUT_CYCLES + 1)) begin
      sinceEdge <= sinceEdge + 1'b1;
    end
  end

  // R2
  edge_acquire_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeStrobe |=> (clkPresent && !lossPulse));

  // R5
  loss_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossPulse |=> !lossPulse);

  // R5
  loss_drops_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossPulse |-> !clkPresent);

  // R5
  present_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkPresent) |-> lossPulse);

  // R3
  loss_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossPulse |-> (seenEdge && sinceEdge == GAP_W'(TIMEOUT_CYCLES)));

  // R4
  present_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkPresent |-> (seenEdge && sinceEdge < GAP_W'(TIMEOUT_CYCLES)));

  // R6
  no_loss_while_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkPresent && !edgeStrobe) |=> !lossPulse);

endmodule

bind clkPresenceWatchdog clkPresenceChecker #(
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .edgeStrobe (edgeStrobe),
  .clkPresent (clkPresent),
  .lossPulse  (lossPulse)
);

// File: tb/tb_clkPresenceWatchdog.sv
module tb_clkPresenceWatchdog;

  localparam int PERIOD  = 20;
  localparam int TIMEOUT = (PERIOD * 11) / 10;   // R3: 22

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic edgeStrobe = 1'b0;
  logic clkPresent, lossPulse;

  int errors = 0;
  int checks = 0;
  int lossCnt = 0;
  int longPulse = 0;
  logic prevLoss = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  clkPresenceWatchdog #(.PERIOD_CYCLES(PERIOD)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .edgeStrobe (edgeStrobe),
    .clkPresent (clkPresent),
    .lossPulse  (lossPulse)
  );

  always @(negedge clk) begin
    if (lossPulse) lossCnt++;
    if (lossPulse && prevLoss) longPulse++;
    prevLoss = lossPulse;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the strobe is sampled on the next rising edge
  task automatic strobeOnce();
    edgeStrobe = 1'b1;
    @(negedge clk);
    edgeStrobe = 1'b0;
  endtask

  task automatic runGap(input int g);
    strobeOnce();
    lossCnt = 0;
    repeat (g - 1) @(negedge clk);
    // R5: presence is gone only if TIMEOUT quiet edges have passed
    check((g - 1 >= TIMEOUT) ? "R5 present before strobe" : "R4 present before strobe",
          int'(clkPresent), (g - 1 >= TIMEOUT) ? 0 : 1);
    strobeOnce();
    if (g == TIMEOUT)
      check("R7 strobe at expiry edge, losses", lossCnt, 0);
    else if (g > TIMEOUT)
      check("R5 gap beyond timeout, losses", lossCnt, 1);
    else
      check("R4 gap within timeout, losses", lossCnt, 0);
    check("R8 present after strobe", int'(clkPresent), 1);
    check("R2 no loss after strobe", int'(lossPulse), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 present in reset", int'(clkPresent), 0);
    check("R1 loss in reset", int'(lossPulse), 0);
    rstN = 1'b1;
    repeat (TIMEOUT + 5) @(negedge clk);
    check("R1 present idle after reset", int'(clkPresent), 0);
    check("R1 no loss idle after reset", lossCnt, 0);

    strobeOnce();
    check("R2 present after first strobe", int'(clkPresent), 1);

    // Exact expiry timing (R3, R5)
    strobeOnce();
    lossCnt = 0;
    repeat (TIMEOUT - 1) @(negedge clk);
    check("R3 no loss one cycle early", int'(lossPulse), 0);
    check("R3 present one cycle early", int'(clkPresent), 1);
    @(negedge clk);
    check("R3 loss on TIMEOUT-th quiet edge", int'(lossPulse), 1);
    check("R5 present falls with loss", int'(clkPresent), 0);
    @(negedge clk);
    check("R5 loss lasts one cycle", int'(lossPulse), 0);

    // Long silence (R6)
    lossCnt = 0;
    repeat (5 * TIMEOUT) @(negedge clk);
    check("R6 no repeat loss", lossCnt, 0);
    check("R6 present stays low", int'(clkPresent), 0);

    // Sweep of gaps between two strobes (R4, R5, R7, R8)
    for (int g = 1; g <= TIMEOUT + 8; g++) begin
      runGap(g);
    end

    // Steady clock at the nominal period keeps presence (R4)
    lossCnt = 0;
    for (int i = 0; i < 30; i++) begin
      strobeOnce();
      repeat (PERIOD - 1) @(negedge clk);
      check("R4 steady clock present", int'(clkPresent), 1);
    end
    check("R4 steady clock no loss", lossCnt, 0);
    check("R5 loss never wider than one cycle", longPulse, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule